// File: doc/BRIEF.md
# Port-Scanning Digital Word Streamer

This block moves 16-bit words between a bank of eight digital ports and two on-chip buffers. On the input side, each sample tick captures the word on one port of a scan list into a 1024-entry capture FIFO. When that FIFO is half full it raises a service request. On the output side, each sample tick takes one word from a 2048-word pattern buffer and drives it onto one port of a second scan list. The port holds that word until the scan list comes back to it.

A scan list has two settings: a first port and a port count. The count must be 1, 2, 4 or 8, and port numbers wrap past the last port back to port 0. The input and output directions are configured separately through one configuration strobe that carries a direction bit. Each direction has its own sample tick. The tick comes either from an internal divider or from the rising edges of a dedicated external clock pin, so the two directions can run at different rates. The output direction has two modes. In replay mode it loops over the stored words with no gap. In streaming mode the buffer is consumed like a FIFO and requests a refill while it is less than half full.

Top module: `port_word_streamer`

## Requirements
- R1: After reset the capture FIFO is empty, cap_req is 0, every output port word is 0, out_en is 0, pat_req is 0 and underrun is 0.
- R2: For an accepted input configuration with first port S and count N, successive captured words come from ports (S+k mod N) mod 8 for k = 0,1,2,... The capture for port p is in_ports[16p+15:16p].
- R3: A configuration whose count is not 1, 2, 4 or 8 (including 0) leaves that direction idle. An idle input captures nothing, and an idle output has out_en = 0.
- R4: With the internal source (cfg_ext = 0) and divider value D, the direction performs one transfer every D+1 clock cycles.
- R5: With the external source (cfg_ext = 1), the direction performs exactly one transfer per rising edge of its external clock pin (ext_in_clk or ext_out_clk).
- R6: The capture FIFO holds 1024 words. cap_req is 1 exactly while it holds 512 or more.
- R7: cap_data shows the oldest captured word, cap_rd removes it, and cap_empty is 1 when no word is held.
- R8: In replay mode (cfg_mode = 0), output transfers walk the words written since the last output configuration in write order. After the last word they wrap to the first with no gap.
- R9: In streaming mode (cfg_mode = 1), each output transfer consumes the oldest written word. pat_req is 1 while the output is active in this mode and fewer than 1024 words are held.
- R10: In streaming mode, a transfer that finds the buffer empty leaves every output port unchanged and sets underrun. underrun stays set until the next output configuration.
- R11: out_en bit p is 1 exactly when port p is in the active output scan list, with wrap past port 7. An output port word changes only on an output transfer to that port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Configuration strobe |
| cfg_dir | input | 1 | Direction selected by the strobe: 0 input, 1 output |
| cfg_start | input | 3 | First port of the scan list |
| cfg_count | input | 4 | Number of ports in the scan list |
| cfg_ext | input | 1 | 1 selects the external clock pin as the sample source |
| cfg_mode | input | 1 | Output mode: 0 replay, 1 streaming |
| cfg_div | input | 16 | Internal divider value D (period D+1 cycles) |
| in_ports | input | 128 | Eight input port words, port p at bits 16p+15:16p |
| ext_in_clk | input | 1 | External sample clock for the input side |
| ext_out_clk | input | 1 | External sample clock for the output side |
| cap_rd | input | 1 | Remove the oldest captured word |
| cap_data | output | 16 | Oldest captured word |
| cap_empty | output | 1 | Capture FIFO empty |
| cap_req | output | 1 | Capture FIFO half-full service request |
| pat_wr | input | 1 | Write one word into the pattern buffer |
| pat_data | input | 16 | Word to write |
| pat_req | output | 1 | Streaming-mode refill request |
| underrun | output | 1 | Sticky streaming-mode empty-transfer flag |
| out_ports | output | 128 | Eight output port words, port p at bits 16p+15:16p |
| out_en | output | 8 | Ports driven by the output scan list |

## Verification
The input ports are held at distinct constant words, so every captured word identifies the port it came from. Scan lists that cross port 7 check the wrap order, and single-port lists give a clean count of transfers. Exact numbers of external edges separate edge counting from level sampling, and they place the FIFO fill exactly at the half-full boundary. Short replay lists driven past their end show whether the replay wraps correctly. Streaming lists that run past the last written word tell holding the last word apart from fetching stale data, and they show whether the underrun flag is sticky.

// File: rtl/ws_pkg.sv
`timescale 1ns/1ps
package ws_pkg;

    typedef enum logic {
        OUT_REPLAY = 1'b0,
        OUT_STREAM = 1'b1
    } out_mode_e;

    // A scan-list length is legal when it is a nonzero power of two no larger
    // than the number of ports.
    function automatic logic count_ok(input int cnt, input int nports);
        return (cnt != 0) && ((cnt & (cnt - 1)) == 0) && (cnt <= nports);
    endfunction

endpackage

// File: rtl/rate_tick.sv
`timescale 1ns/1ps
module rate_tick #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             use_ext,
    input  logic [DIV_W-1:0] div,
    input  logic             ext_clk,
    output logic             tick
);

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic [2:0]       sync;
    } tick_t;

    tick_t st_d, st_q;
    logic  int_hit;
    logic  ext_rise;

    always_comb begin
        int_hit     = (st_q.cnt == div);
        ext_rise    = st_q.sync[1] & ~st_q.sync[2];
        tick        = use_ext ? ext_rise : int_hit;
        st_d.sync   = {st_q.sync[1:0], ext_clk};
        st_d.cnt    = (int_hit || use_ext) ? '0 : st_q.cnt + 1'b1;
        if (restart) st_d.cnt = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R4: the internal divider never runs past its terminal value
    a_r4_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        !use_ext |-> (st_q.cnt <= div));

    // R5: an external-source tick needs a low-to-high step of the synchronizer
    a_r5_edge_only: assert property (@(posedge clk) disable iff (!rst_n)
        (use_ext && tick) |=> !$past(st_q.sync[2]));

endmodule

// File: rtl/scan_seq.sv
`timescale 1ns/1ps
module scan_seq #(
    parameter int PIDX_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              step,
    input  logic [PIDX_W-1:0] start,
    input  logic [PIDX_W:0]   count,
    output logic [PIDX_W-1:0] port
);

    logic [PIDX_W-1:0] idx_d, idx_q;
    logic [PIDX_W:0]   nxt;
    logic [PIDX_W:0]   mask;

    always_comb begin
        nxt   = {1'b0, idx_q} + 1'b1;
        mask  = count - 1'b1;
        port  = start + idx_q;
        idx_d = idx_q;
        if (restart)   idx_d = '0;
        else if (step) idx_d = nxt[PIDX_W-1:0] & mask[PIDX_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) idx_q <= '0;
        else        idx_q <= idx_d;
    end

    // R2: the position inside the list stays below the list length
    a_r2_idx_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        (count != 0) |-> ({1'b0, idx_q} < count));

endmodule

// File: rtl/word_fifo.sv
`timescale 1ns/1ps
module word_fifo #(
    parameter int W     = 16,
    parameter int DEPTH = 1024,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr,
    input  logic [W-1:0]  wdata,
    input  logic          rd,
    output logic [W-1:0]  rdata,
    output logic [AW:0]   level
);

    localparam logic [AW:0] LVL_FULL = (AW+1)'(DEPTH);

    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [AW:0]   lvl;
    } fifo_t;

    fifo_t        st_d, st_q;
    logic [W-1:0] mem [DEPTH];
    logic         wr_ok;
    logic         rd_ok;

    always_comb begin
        wr_ok = wr && (st_q.lvl != LVL_FULL);
        rd_ok = rd && (st_q.lvl != '0);
        st_d  = st_q;
        if (wr_ok) st_d.wp = st_q.wp + 1'b1;
        if (rd_ok) st_d.rp = st_q.rp + 1'b1;
        st_d.lvl = st_q.lvl + {{AW{1'b0}}, wr_ok} - {{AW{1'b0}}, rd_ok};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (wr_ok) mem[st_q.wp] <= wdata;
    end

    assign rdata = mem[st_q.rp];
    assign level = st_q.lvl;

    // R6: the fill level never exceeds the capacity
    a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.lvl <= LVL_FULL);

    // R7: the level moves by at most one word per cycle
    a_r7_level_step: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.lvl == $past(st_q.lvl)) || (st_q.lvl == $past(st_q.lvl) + 1'b1) ||
        (st_q.lvl == $past(st_q.lvl) - 1'b1));

endmodule

// File: rtl/pattern_buf.sv
`timescale 1ns/1ps
module pattern_buf import ws_pkg::*; #(
    parameter int W     = 16,
    parameter int DEPTH = 2048,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  out_mode_e     mode,
    input  logic          wr,
    input  logic [W-1:0]  wdata,
    input  logic          pop,
    output logic [W-1:0]  word,
    output logic          word_ok,
    output logic [AW:0]   level,
    output logic          underrun
);

    localparam logic [AW:0] LVL_FULL = (AW+1)'(DEPTH);

    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [AW:0]   lvl;
        logic          urun;
    } pbuf_t;

    pbuf_t        st_d, st_q;
    logic [W-1:0] mem [DEPTH];
    logic         wr_ok;
    logic         has_word;
    logic         consume;
    logic [AW:0]  rp_inc;

    always_comb begin
        wr_ok    = wr && !clear && (st_q.lvl != LVL_FULL);
        has_word = (st_q.lvl != '0);
        word_ok  = pop && has_word;
        consume  = word_ok && (mode == OUT_STREAM);
        rp_inc   = {1'b0, st_q.rp} + 1'b1;
        st_d     = st_q;
        if (wr_ok) st_d.wp = st_q.wp + 1'b1;
        if (word_ok) begin
            if (mode == OUT_REPLAY) st_d.rp = (rp_inc >= st_q.lvl) ? '0 : rp_inc[AW-1:0];
            else                    st_d.rp = rp_inc[AW-1:0];
        end
        st_d.lvl = st_q.lvl + {{AW{1'b0}}, wr_ok} - {{AW{1'b0}}, consume};
        if (pop && !has_word && (mode == OUT_STREAM)) st_d.urun = 1'b1;
        if (clear) st_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (wr_ok) mem[st_q.wp] <= wdata;
    end

    assign word     = mem[st_q.rp];
    assign level    = st_q.lvl;
    assign underrun = st_q.urun;

    // R8: in replay mode the read position stays inside the stored words
    a_r8_rp_inside: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode == OUT_REPLAY) && (st_q.lvl != '0)) |-> ({1'b0, st_q.rp} < st_q.lvl));

    // R10: the underrun flag only exists in streaming mode
    a_r10_underrun_stream: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.urun |-> (mode == OUT_STREAM));

    // R10: once set, the flag holds until a clear
    a_r10_underrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(st_q.urun) && !$past(clear)) |-> st_q.urun);

endmodule

// File: rtl/port_word_streamer.sv
`timescale 1ns/1ps
module port_word_streamer import ws_pkg::*; #(
    parameter int WORD_W    = 16,
    parameter int NPORTS    = 8,
    parameter int CAP_DEPTH = 1024,
    parameter int PAT_DEPTH = 2048,
    parameter int DIV_W     = 16,
    localparam int PIDX_W   = $clog2(NPORTS),
    localparam int CNT_W    = PIDX_W + 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cfg_wr,
    input  logic                     cfg_dir,
    input  logic [PIDX_W-1:0]        cfg_start,
    input  logic [CNT_W-1:0]         cfg_count,
    input  logic                     cfg_ext,
    input  logic                     cfg_mode,
    input  logic [DIV_W-1:0]         cfg_div,
    input  logic [NPORTS*WORD_W-1:0] in_ports,
    input  logic                     ext_in_clk,
    input  logic                     ext_out_clk,
    input  logic                     cap_rd,
    output logic [WORD_W-1:0]        cap_data,
    output logic                     cap_empty,
    output logic                     cap_req,
    input  logic                     pat_wr,
    input  logic [WORD_W-1:0]        pat_data,
    output logic                     pat_req,
    output logic                     underrun,
    output logic [NPORTS*WORD_W-1:0] out_ports,
    output logic [NPORTS-1:0]        out_en
);

    localparam int CAP_AW = $clog2(CAP_DEPTH);
    localparam int PAT_AW = $clog2(PAT_DEPTH);
    localparam logic [CAP_AW:0] CAP_HALF = (CAP_AW+1)'(CAP_DEPTH / 2);
    localparam logic [PAT_AW:0] PAT_HALF = (PAT_AW+1)'(PAT_DEPTH / 2);

    typedef struct packed {
        logic                           in_act;
        logic [PIDX_W-1:0]              in_start;
        logic [CNT_W-1:0]               in_cnt;
        logic                           in_ext;
        logic [DIV_W-1:0]               in_div;
        logic                           out_act;
        logic [PIDX_W-1:0]              out_start;
        logic [CNT_W-1:0]               out_cnt;
        logic                           out_ext;
        logic [DIV_W-1:0]               out_div;
        out_mode_e                      out_mode;
        logic [NPORTS-1:0][WORD_W-1:0]  bank;
    } top_t;

    top_t st_d, st_q;

    logic              in_restart, out_restart, cfg_good;
    logic              in_tick, out_tick, in_step, out_step;
    logic [PIDX_W-1:0] in_port, out_port;
    logic [CAP_AW:0]   cap_level;
    logic [PAT_AW:0]   pat_level;
    logic [WORD_W-1:0] pop_word;
    logic              pop_ok;

    assign cfg_good    = count_ok(int'(cfg_count), NPORTS);
    assign in_restart  = cfg_wr && !cfg_dir;
    assign out_restart = cfg_wr &&  cfg_dir;
    assign in_step     = in_tick  && st_q.in_act  && !in_restart;
    assign out_step    = out_tick && st_q.out_act && !out_restart;

    rate_tick #(.DIV_W(DIV_W)) u_in_rate (
        .clk(clk), .rst_n(rst_n), .restart(in_restart), .use_ext(st_q.in_ext),
        .div(st_q.in_div), .ext_clk(ext_in_clk), .tick(in_tick));

    rate_tick #(.DIV_W(DIV_W)) u_out_rate (
        .clk(clk), .rst_n(rst_n), .restart(out_restart), .use_ext(st_q.out_ext),
        .div(st_q.out_div), .ext_clk(ext_out_clk), .tick(out_tick));

    scan_seq #(.PIDX_W(PIDX_W)) u_in_scan (
        .clk(clk), .rst_n(rst_n), .restart(in_restart), .step(in_step),
        .start(st_q.in_start), .count(st_q.in_cnt), .port(in_port));

    scan_seq #(.PIDX_W(PIDX_W)) u_out_scan (
        .clk(clk), .rst_n(rst_n), .restart(out_restart), .step(out_step),
        .start(st_q.out_start), .count(st_q.out_cnt), .port(out_port));

    word_fifo #(.W(WORD_W), .DEPTH(CAP_DEPTH)) u_cap (
        .clk(clk), .rst_n(rst_n), .wr(in_step),
        .wdata(in_ports[in_port*WORD_W +: WORD_W]),
        .rd(cap_rd), .rdata(cap_data), .level(cap_level));

    pattern_buf #(.W(WORD_W), .DEPTH(PAT_DEPTH)) u_pat (
        .clk(clk), .rst_n(rst_n), .clear(out_restart), .mode(st_q.out_mode),
        .wr(pat_wr), .wdata(pat_data), .pop(out_step), .word(pop_word),
        .word_ok(pop_ok), .level(pat_level), .underrun(underrun));

    always_comb begin
        st_d = st_q;
        if (in_restart) begin
            st_d.in_act   = cfg_good;
            st_d.in_start = cfg_start;
            st_d.in_cnt   = cfg_count;
            st_d.in_ext   = cfg_ext;
            st_d.in_div   = cfg_div;
        end
        if (out_restart) begin
            st_d.out_act   = cfg_good;
            st_d.out_start = cfg_start;
            st_d.out_cnt   = cfg_count;
            st_d.out_ext   = cfg_ext;
            st_d.out_div   = cfg_div;
            st_d.out_mode  = out_mode_e'(cfg_mode);
        end
        if (pop_ok) st_d.bank[out_port] = pop_word;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        for (int p = 0; p < NPORTS; p++) begin
            out_en[p] = st_q.out_act &&
                ({1'b0, PIDX_W'(PIDX_W'(p) - st_q.out_start)} < st_q.out_cnt);
        end
    end

    assign out_ports = st_q.bank;
    assign cap_empty = (cap_level == '0);
    assign cap_req   = (cap_level >= CAP_HALF);
    assign pat_req   = st_q.out_act && (st_q.out_mode == OUT_STREAM) && (pat_level < PAT_HALF);

    // R3: an illegal length written for the input side leaves it idle
    a_r3_reject_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (in_restart && !cfg_good) |=> !st_q.in_act);

    // R3: an idle input side adds nothing to the capture FIFO
    a_r3_idle_no_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.in_act && !cap_rd) |=> (cap_level == $past(cap_level)));

    // R11: the port words only move when the pattern buffer hands out a word
    a_r11_bank_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !pop_ok |=> $stable(st_q.bank));

    // R11: the driven-port mask covers either no port or a power-of-two group
    a_r11_en_group: assert property (@(posedge clk) disable iff (!rst_n)
        (out_en & (out_en - 1'b1)) == '0 || $countones(out_en) == int'(st_q.out_cnt));

endmodule

// File: tb/sim_port_word_streamer.sv
`timescale 1ns/1ps
module sim_port_word_streamer;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cfg_wr = 1'b0, cfg_dir = 1'b0, cfg_ext = 1'b0, cfg_mode = 1'b0;
    logic [2:0]   cfg_start = '0;
    logic [3:0]   cfg_count = '0;
    logic [15:0]  cfg_div = '0;
    logic [127:0] in_ports;
    logic         ext_in_clk = 1'b0, ext_out_clk = 1'b0;
    logic         cap_rd = 1'b0;
    logic [15:0]  cap_data;
    logic         cap_empty, cap_req;
    logic         pat_wr = 1'b0;
    logic [15:0]  pat_data = '0;
    logic         pat_req, underrun;
    logic [127:0] out_ports;
    logic [7:0]   out_en;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    port_word_streamer u0 (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_dir(cfg_dir),
        .cfg_start(cfg_start), .cfg_count(cfg_count), .cfg_ext(cfg_ext),
        .cfg_mode(cfg_mode), .cfg_div(cfg_div), .in_ports(in_ports),
        .ext_in_clk(ext_in_clk), .ext_out_clk(ext_out_clk), .cap_rd(cap_rd),
        .cap_data(cap_data), .cap_empty(cap_empty), .cap_req(cap_req),
        .pat_wr(pat_wr), .pat_data(pat_data), .pat_req(pat_req),
        .underrun(underrun), .out_ports(out_ports), .out_en(out_en));

    function automatic logic [15:0] in_word(input int p);
        return 16'hA000 + 16'(p);
    endfunction

    function automatic logic [15:0] out_word(input int p);
        return out_ports[p*16 +: 16];
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_cfg(input bit dir, input int start, input int cnt, input bit ext,
                          input bit mode, input int div);
        @(negedge clk);
        cfg_dir = dir; cfg_start = 3'(start); cfg_count = 4'(cnt);
        cfg_ext = ext; cfg_mode = mode; cfg_div = 16'(div); cfg_wr = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic pulses(input bit on_out, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (on_out) ext_out_clk = 1'b1; else ext_in_clk = 1'b1;
            repeat (3) @(negedge clk);
            if (on_out) ext_out_clk = 1'b0; else ext_in_clk = 1'b0;
            repeat (3) @(negedge clk);
        end
    endtask

    // Pops up to maxn words, checking each against the scan order (R2, R7).
    task automatic drain(input int start, input int cnt, input int offset, input int maxn,
                         input string tag, output int n);
        n = 0;
        @(negedge clk);
        while (n < maxn && !cap_empty) begin
            chk(cap_data == in_word((start + ((offset + n) % cnt)) % 8), tag,
                cap_data, in_word((start + ((offset + n) % cnt)) % 8));
            cap_rd = 1'b1;
            @(negedge clk);
            n++;
        end
        cap_rd = 1'b0;
    endtask

    task automatic write_pat(input logic [15:0] w);
        @(negedge clk);
        pat_wr = 1'b1; pat_data = w;
        @(negedge clk);
        pat_wr = 1'b0;
    endtask

    task automatic t_reset;
        chk(cap_empty == 1'b1, "R1 cap_empty", cap_empty, 1);
        chk(cap_req == 1'b0, "R1 cap_req", cap_req, 0);
        chk(out_ports == '0, "R1 out_ports", out_ports, 0);
        chk(out_en == '0, "R1 out_en", out_en, 0);
        chk(pat_req == 1'b0 && underrun == 1'b0, "R1 pat_req/underrun",
            {pat_req, underrun}, 0);
    endtask

    task automatic t_scan_wrap;
        int n;
        do_cfg(1'b0, 6, 4, 1'b0, 1'b0, 0);
        repeat (20) @(negedge clk);
        do_cfg(1'b0, 0, 0, 1'b0, 1'b0, 0);
        drain(6, 4, 0, 4096, "R2 scan order 6,7,0,1", n);
        chk(n >= 19 && n <= 23, "R7 words drained", n, 21);
        chk(cap_empty == 1'b1, "R7 empty after drain", cap_empty, 1);
    endtask

    task automatic t_reject;
        do_cfg(1'b0, 0, 3, 1'b0, 1'b0, 0);
        repeat (40) @(negedge clk);
        chk(cap_empty == 1'b1, "R3 count 3 captures nothing", cap_empty, 1);
        do_cfg(1'b1, 2, 5, 1'b0, 1'b0, 0);
        chk(out_en == '0, "R3 count 5 leaves output idle", out_en, 0);
    endtask

    task automatic t_rate;
        int n;
        do_cfg(1'b0, 1, 1, 1'b0, 1'b0, 4);
        repeat (99) @(negedge clk);
        do_cfg(1'b0, 0, 0, 1'b0, 1'b0, 0);
        drain(1, 1, 0, 4096, "R4 port 1 words", n);
        chk(n >= 19 && n <= 21, "R4 one word per 5 cycles over 100", n, 20);
    endtask

    task automatic t_ext_half;
        int n;
        do_cfg(1'b0, 0, 2, 1'b1, 1'b0, 0);
        pulses(1'b0, 520);
        repeat (5) @(negedge clk);
        do_cfg(1'b0, 0, 0, 1'b0, 1'b0, 0);
        chk(cap_req == 1'b1, "R6 request at 520 words", cap_req, 1);
        drain(0, 2, 0, 8, "R6 first words", n);
        chk(cap_req == 1'b1, "R6 request held at 512 words", cap_req, 1);
        drain(0, 2, 8, 1, "R6 word 9", n);
        chk(cap_req == 1'b0, "R6 request drops at 511 words", cap_req, 0);
        drain(0, 2, 9, 4096, "R5 remaining order", n);
        chk(n == 511, "R5 one word per external edge", n, 511);
    endtask

    task automatic t_replay;
        do_cfg(1'b1, 2, 2, 1'b1, 1'b0, 0);
        chk(out_en == 8'b0000_1100, "R11 mask for ports 2,3", out_en, 8'b0000_1100);
        write_pat(16'h1111);
        write_pat(16'h2222);
        write_pat(16'h3333);
        pulses(1'b1, 4);
        chk(out_word(2) == 16'h3333, "R8 port2 after 4 transfers", out_word(2), 16'h3333);
        chk(out_word(3) == 16'h1111, "R8 port3 wraps to first word", out_word(3), 16'h1111);
        pulses(1'b1, 2);
        chk(out_word(2) == 16'h2222 && out_word(3) == 16'h3333, "R8 continued replay",
            {out_word(2), out_word(3)}, 32'h2222_3333);
        chk(out_word(0) == 16'h0 && out_word(5) == 16'h0, "R11 unlisted ports untouched",
            {out_word(0), out_word(5)}, 0);
    endtask

    task automatic t_stream;
        do_cfg(1'b1, 7, 1, 1'b1, 1'b1, 0);
        chk(pat_req == 1'b1 && underrun == 1'b0, "R9 request on empty stream buffer",
            {pat_req, underrun}, 2'b10);
        write_pat(16'hB0B0);
        write_pat(16'hB1B1);
        pulses(1'b1, 1);
        chk(out_word(7) == 16'hB0B0, "R9 first streamed word", out_word(7), 16'hB0B0);
        pulses(1'b1, 1);
        chk(out_word(7) == 16'hB1B1 && underrun == 1'b0, "R9 second streamed word",
            {underrun, out_word(7)}, 17'h0B1B1);
        pulses(1'b1, 1);
        chk(out_word(7) == 16'hB1B1, "R10 word held on empty transfer", out_word(7), 16'hB1B1);
        chk(underrun == 1'b1, "R10 underrun set", underrun, 1);
        write_pat(16'hC0C0);
        chk(underrun == 1'b1, "R10 underrun sticky", underrun, 1);
        chk(out_word(2) == 16'h2222, "R11 port2 unchanged by stream", out_word(2), 16'h2222);
    endtask

    task automatic t_refill;
        do_cfg(1'b1, 6, 4, 1'b0, 1'b1, 16'hFFFF);
        chk(underrun == 1'b0, "R10 cleared by configuration", underrun, 0);
        chk(out_en == 8'b1100_0011, "R11 mask wraps past port 7", out_en, 8'b1100_0011);
        @(negedge clk);
        pat_wr = 1'b1;
        for (int i = 0; i < 1023; i++) begin
            pat_data = 16'(i);
            @(negedge clk);
        end
        pat_wr = 1'b0;
        chk(pat_req == 1'b1, "R9 request at 1023 words", pat_req, 1);
        write_pat(16'h7777);
        chk(pat_req == 1'b0, "R9 request drops at 1024 words", pat_req, 0);
    endtask

    initial begin
        for (int p = 0; p < 8; p++) in_ports[p*16 +: 16] = in_word(p);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_scan_wrap();
        t_reject();
        t_rate();
        t_ext_half();
        t_replay();
        t_stream();
        t_refill();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule